// File: doc/BRIEF.md
# Per-Cycle Edge Timestamp Latch

This block watches one digital input per channel and stamps every rising and falling edge with the value of a free-running time counter. It does this on its own clock. Between two cycle boundary pulses it keeps, for each channel and each polarity, exactly one timestamp. At each boundary pulse it copies that timestamp, together with a status byte, into output registers. A host then reads those registers as process data once per control cycle.

Each polarity of each channel has its own capture mode, set by a per-channel control byte. In keep-last mode, every new edge replaces the held stamp. In keep-first mode, the first edge of the cycle is held and later edges of that polarity are ignored. Keep-first mode also reports, through a per-cycle flag, whether that polarity saw an edge. A mode written through the register port is only used from the next boundary pulse onward, so a capture that is already running is never reinterpreted.

Top module: `edge_ts_latch`

## Requirements
- R1: `time_o` is 0 after reset and increases by one on every clock.
- R2: Each input passes through two synchronising flops. An input change applied while `time_o` reads T is stamped with the value T+2.
- R3: In keep-last mode (mode bit 0, the reset value), a polarity's output timestamp after a boundary pulse is the stamp of the last edge of that polarity in the cycle that just ended.
- R4: In keep-first mode (mode bit 1), the output timestamp is the stamp of the first edge of that polarity in the ended cycle. Later edges of that polarity in the same cycle have no effect.
- R5: Control byte bit 0 sets the rising-edge mode and bit 1 sets the falling-edge mode. The two polarities are independent. Bits 7..2 have no effect.
- R6: Outputs change only in the clock of a boundary pulse. If a polarity had no edge in the ended cycle, its output timestamp keeps its previous value.
- R7: An edge detected in the same clock as a boundary pulse belongs to the new cycle.
- R8: Status byte per channel: bit 0 is set when a rising edge occurred in the ended cycle and rising mode was keep-first; bit 1 is the same for falling edges; bit 2 is the synchronised input level at the boundary pulse; bits 7..3 are 0. In keep-last mode, bits 0 and 1 read 0.
- R9: A control write takes effect at the next boundary pulse. A write in the same clock as a boundary pulse takes effect at the pulse after that.
- R10: After reset, all output timestamps and status bytes are 0 and every mode is keep-last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_i | input | NUM_CH | Monitored inputs, asynchronous |
| cyc_tick_i | input | 1 | Cycle boundary pulse, one clock wide |
| wr_en_i | input | 1 | Control byte write strobe |
| wr_ch_i | input | CH_W | Channel addressed by the write |
| wr_data_i | input | 8 | Control byte |
| time_o | output | TS_W | Free-running time counter |
| rise_ts_o | output | NUM_CH*TS_W | Rising-edge timestamps, channel c at [c*TS_W +: TS_W] |
| fall_ts_o | output | NUM_CH*TS_W | Falling-edge timestamps, same packing |
| status_o | output | NUM_CH*8 | Status bytes, channel c at [c*8 +: 8] |

## Verification
The hardest cases to reach from the ports are the ones where timing lines up. The first is an edge whose synchronised detection lands exactly in a boundary clock. The second is a control write issued in the same clock as a boundary pulse. For the first, the stimulus changes an input and raises the boundary pulse exactly two clocks later, using the fixed synchroniser latency. For the second, the write and the pulse are driven together, and the stamps of two later cycles show when the new mode took hold. A long random phase with sparse toggles, pulses and writes is then compared against a behavioural model on every clock.

// File: rtl/edge_ts_pkg.sv
package edge_ts_pkg;
  localparam int CTRL_W    = 8;
  localparam int STAT_W    = 8;
  localparam int ST_RISE   = 0;
  localparam int ST_FALL   = 1;
  localparam int ST_LEVEL  = 2;
  localparam int SYNC_LEN  = 2;

  typedef enum logic {
    MODE_LAST  = 1'b0,
    MODE_FIRST = 1'b1
  } cap_mode_e;
endpackage

// File: rtl/edge_ts_sync.sv
module edge_ts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sr_q   <= {sr_q[STAGES-2:0], d_i};
      prev_q <= sr_q[STAGES-1];
    end
  end

  assign level_o = sr_q[STAGES-1];
  assign rise_o  = sr_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~sr_q[STAGES-1] & prev_q;
endmodule

// File: rtl/edge_ts_capture.sv
module edge_ts_capture
  import edge_ts_pkg::*;
#(
  parameter int TS_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            edge_i,
  input  cap_mode_e       mode_i,
  input  logic [TS_W-1:0] time_i,
  output logic [TS_W-1:0] ts_o,
  output logic            flag_o,
  output logic            seen_o,
  output logic [TS_W-1:0] hold_o
);
  logic            seen_q;
  logic [TS_W-1:0] hold_q;
  logic            locked;

  assign locked = seen_q && (mode_i == MODE_FIRST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      hold_q <= '0;
      ts_o   <= '0;
      flag_o <= 1'b0;
    end else if (tick_i) begin
      if (seen_q) ts_o <= hold_q;
      flag_o <= locked;
      // edge in boundary clock opens the new cycle
      seen_q <= edge_i;
      if (edge_i) hold_q <= time_i;
    end else if (edge_i && !locked) begin
      seen_q <= 1'b1;
      hold_q <= time_i;
    end
  end

  assign seen_o = seen_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/edge_ts_chan.sv
module edge_ts_chan
  import edge_ts_pkg::*;
#(
  parameter int TS_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sig_i,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [1:0]        wr_mode_i,
  input  logic [TS_W-1:0]   time_i,
  output logic [TS_W-1:0]   rise_ts_o,
  output logic [TS_W-1:0]   fall_ts_o,
  output logic [STAT_W-1:0] status_o,
  output logic [1:0]        mode_o,
  output logic              rise_seen_o,
  output logic [TS_W-1:0]   rise_hold_o
);
  logic       level, rise_det, fall_det;
  logic [1:0] shadow_q, mode_q;
  logic       lvl_q, rise_flag, fall_flag;
  logic       fall_seen_unused;
  logic [TS_W-1:0] fall_hold_unused;

  edge_ts_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sig_i),
    .level_o(level),
    .rise_o (rise_det),
    .fall_o (fall_det)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      mode_q   <= '0;
      lvl_q    <= 1'b0;
    end else begin
      if (wr_i) shadow_q <= wr_mode_i;
      if (tick_i) begin
        mode_q <= shadow_q;
        lvl_q  <= level;
      end
    end
  end

  edge_ts_capture #(.TS_W(TS_W)) u_rise (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .edge_i(rise_det),
    .mode_i(cap_mode_e'(mode_q[0])),
    .time_i(time_i),
    .ts_o  (rise_ts_o),
    .flag_o(rise_flag),
    .seen_o(rise_seen_o),
    .hold_o(rise_hold_o)
  );

  edge_ts_capture #(.TS_W(TS_W)) u_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .edge_i(fall_det),
    .mode_i(cap_mode_e'(mode_q[1])),
    .time_i(time_i),
    .ts_o  (fall_ts_o),
    .flag_o(fall_flag),
    .seen_o(fall_seen_unused),
    .hold_o(fall_hold_unused)
  );

  always_comb begin
    status_o           = '0;
    status_o[ST_RISE]  = rise_flag;
    status_o[ST_FALL]  = fall_flag;
    status_o[ST_LEVEL] = lvl_q;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/edge_ts_latch.sv
module edge_ts_latch
  import edge_ts_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int TS_W   = 32,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH-1:0]        sig_i,
  input  logic                     cyc_tick_i,
  input  logic                     wr_en_i,
  input  logic [CH_W-1:0]          wr_ch_i,
  input  logic [CTRL_W-1:0]        wr_data_i,
  output logic [TS_W-1:0]          time_o,
  output logic [NUM_CH*TS_W-1:0]   rise_ts_o,
  output logic [NUM_CH*TS_W-1:0]   fall_ts_o,
  output logic [NUM_CH*STAT_W-1:0] status_o
);
  logic [TS_W-1:0]        time_q;
  logic [NUM_CH*2-1:0]    mode_all;
  logic [NUM_CH-1:0]      rise_seen_all;
  logic [NUM_CH*TS_W-1:0] rise_hold_all;
  logic                   unused_ctrl_bits;

  assign unused_ctrl_bits = ^wr_data_i[CTRL_W-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) time_q <= '0;
    else         time_q <= time_q + TS_W'(1);
  end
  assign time_o = time_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    edge_ts_chan #(.TS_W(TS_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sig_i      (sig_i[c]),
      .tick_i     (cyc_tick_i),
      .wr_i       (wr_en_i && (wr_ch_i == CH_W'(c))),
      .wr_mode_i  (wr_data_i[1:0]),
      .time_i     (time_q),
      .rise_ts_o  (rise_ts_o[c*TS_W +: TS_W]),
      .fall_ts_o  (fall_ts_o[c*TS_W +: TS_W]),
      .status_o   (status_o[c*STAT_W +: STAT_W]),
      .mode_o     (mode_all[c*2 +: 2]),
      .rise_seen_o(rise_seen_all[c]),
      .rise_hold_o(rise_hold_all[c*TS_W +: TS_W])
    );
  end
endmodule

// File: rtl/edge_ts_latch_chk.sv
module edge_ts_latch_chk #(
  parameter int NUM_CH = 4,
  parameter int TS_W   = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cyc_tick_i,
  input logic [TS_W-1:0]        time_o,
  input logic [NUM_CH*TS_W-1:0] rise_ts_o,
  input logic [NUM_CH*TS_W-1:0] fall_ts_o,
  input logic [NUM_CH*8-1:0]    status_o,
  input logic [NUM_CH*2-1:0]    mode_all,
  input logic [NUM_CH-1:0]      rise_seen_all,
  input logic [NUM_CH*TS_W-1:0] rise_hold_all
);
  assert_time_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> time_o == $past(time_o) + TS_W'(1));

  assert_quiet_outputs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_tick_i |=> $stable(rise_ts_o) && $stable(fall_ts_o) && $stable(status_o));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    assert_first_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_all[c*2] && rise_seen_all[c] && !cyc_tick_i) |=> $stable(rise_hold_all[c*TS_W +: TS_W]));

    assert_rise_flag_mode_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_tick_i && !mode_all[c*2]) |=> !status_o[c*8]);

    assert_fall_flag_mode_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_tick_i && !mode_all[c*2+1]) |=> !status_o[c*8+1]);

    assert_pad_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o[c*8+3 +: 5] == 5'd0);
  end
endmodule

bind edge_ts_latch edge_ts_latch_chk #(.NUM_CH(NUM_CH), .TS_W(TS_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cyc_tick_i   (cyc_tick_i),
  .time_o       (time_o),
  .rise_ts_o    (rise_ts_o),
  .fall_ts_o    (fall_ts_o),
  .status_o     (status_o),
  .mode_all     (mode_all),
  .rise_seen_all(rise_seen_all),
  .rise_hold_all(rise_hold_all)
);

// File: tb/edge_ts_latch_tb.sv
module edge_ts_latch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int TW = 32;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] sig = '0;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_ch = '0;
  logic [7:0] wr_data = '0;
  logic [TW-1:0] time_w;
  logic [NCH*TW-1:0] rise_w, fall_w;
  logic [NCH*8-1:0] stat_w;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_ts_latch #(.NUM_CH(NCH), .TS_W(TW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sig_i(sig), .cyc_tick_i(tick),
    .wr_en_i(wr_en), .wr_ch_i(wr_ch), .wr_data_i(wr_data),
    .time_o(time_w), .rise_ts_o(rise_w), .fall_ts_o(fall_w), .status_o(stat_w)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic       m_s1[NCH], m_s2[NCH], m_pv[NCH], m_lvl[NCH];
  logic [1:0] m_sh[NCH], m_md[NCH];
  logic       m_seen[NCH][2], m_flag[NCH][2];
  logic [31:0] m_hold[NCH][2], m_ts[NCH][2];
  logic [31:0] m_time;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_time = 0;
      for (int c = 0; c < NCH; c++) begin
        m_s1[c] = 0; m_s2[c] = 0; m_pv[c] = 0; m_lvl[c] = 0;
        m_sh[c] = 0; m_md[c] = 0;
        for (int p = 0; p < 2; p++) begin
          m_seen[c][p] = 0; m_flag[c][p] = 0; m_hold[c][p] = 0; m_ts[c][p] = 0;
        end
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        logic det[2];
        det[0] = m_s2[c] & ~m_pv[c];
        det[1] = ~m_s2[c] & m_pv[c];
        for (int p = 0; p < 2; p++) begin
          if (tick) begin
            if (m_seen[c][p]) m_ts[c][p] = m_hold[c][p];
            m_flag[c][p] = m_seen[c][p] & m_md[c][p];
            m_seen[c][p] = det[p];
            if (det[p]) m_hold[c][p] = m_time;
          end else if (det[p] && !(m_seen[c][p] && m_md[c][p])) begin
            m_seen[c][p] = 1;
            m_hold[c][p] = m_time;
          end
        end
        if (tick) begin
          m_lvl[c] = m_s2[c];
          m_md[c] = m_sh[c];
        end
        m_pv[c] = m_s2[c]; m_s2[c] = m_s1[c]; m_s1[c] = sig[c];
        if (wr_en && wr_ch == 2'(c)) m_sh[c] = wr_data[1:0];
      end
      m_time = m_time + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1", "time", time_w, m_time);
      for (int c = 0; c < NCH; c++) begin
        chk("R3", $sformatf("rise ts ch%0d", c), rise_w[c*TW +: TW], m_ts[c][0]);
        chk("R3", $sformatf("fall ts ch%0d", c), fall_w[c*TW +: TW], m_ts[c][1]);
        chk("R8", $sformatf("status ch%0d", c), {24'd0, stat_w[c*8 +: 8]},
            {29'd0, m_lvl[c], m_flag[c][1], m_flag[c][0]});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1; cyc(1); tick = 1'b0;
  endtask

  task automatic wr(int ch, logic [7:0] d);
    wr_en = 1'b1; wr_ch = 2'(ch); wr_data = d; cyc(1); wr_en = 1'b0;
  endtask

  initial begin
    logic [31:0] tr1, tf1, tr2, tf2, t0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R10 reset state
    chk("R10", "rise ts after reset", rise_w[31:0], 0);
    chk("R10", "fall ts after reset", fall_w[63:32], 0);
    chk("R10", "status after reset", {stat_w}, 0);
    t0 = time_w;
    cyc(1);
    chk("R1", "time increments", time_w, t0 + 1);

    // ch1 keep-first both polarities, ch0 keep-last
    wr(1, 8'h03);
    pulse_tick();
    sig[1:0] = 2'b11; tr1 = time_w; cyc(4);
    sig[1:0] = 2'b00; tf1 = time_w; cyc(4);
    sig[1:0] = 2'b11; tr2 = time_w; cyc(4);
    sig[1:0] = 2'b00; tf2 = time_w; cyc(4);
    pulse_tick();
    chk("R3", "ch0 last rise", rise_w[0 +: 32], tr2 + 2);
    chk("R3", "ch0 last fall", fall_w[0 +: 32], tf2 + 2);
    chk("R2", "stamp latency", rise_w[0 +: 32] - tr2, 2);
    chk("R8", "ch0 status keep-last", {24'd0, stat_w[7:0]}, 0);
    chk("R4", "ch1 first rise", rise_w[32 +: 32], tr1 + 2);
    chk("R4", "ch1 first fall", fall_w[32 +: 32], tf1 + 2);
    chk("R8", "ch1 status flags", {24'd0, stat_w[15:8]}, 32'h03);

    // empty cycle keeps stamps
    cyc(3);
    pulse_tick();
    chk("R6", "ch0 rise kept", rise_w[0 +: 32], tr2 + 2);
    chk("R6", "ch1 rise kept", rise_w[32 +: 32], tr1 + 2);
    chk("R8", "ch1 flags cleared", {24'd0, stat_w[15:8]}, 0);

    // R7 edge detected in boundary clock
    sig[2] = 1'b1; t0 = time_w; cyc(2);
    pulse_tick();
    chk("R7", "ch2 rise not in old cycle", rise_w[64 +: 32], 0);
    chk("R8", "ch2 level bit", {24'd0, stat_w[23:16]}, 32'h04);
    cyc(3);
    pulse_tick();
    chk("R7", "ch2 rise in new cycle", rise_w[64 +: 32], t0 + 2);

    // R9 write coinciding with boundary
    tick = 1'b1; wr_en = 1'b1; wr_ch = 2'd3; wr_data = 8'h01; cyc(1);
    tick = 1'b0; wr_en = 1'b0;
    sig[3] = 1'b1; tr1 = time_w; cyc(4);
    sig[3] = 1'b0; cyc(4);
    sig[3] = 1'b1; tr2 = time_w; cyc(4);
    pulse_tick();
    chk("R9", "ch3 still keep-last", rise_w[96 +: 32], tr2 + 2);
    chk("R9", "ch3 no flag yet", {24'd0, stat_w[31:24]}, 32'h04);
    sig[3] = 1'b0; cyc(4);
    sig[3] = 1'b1; tr1 = time_w; cyc(4);
    sig[3] = 1'b0; cyc(4);
    sig[3] = 1'b1; tr2 = time_w; cyc(4);
    pulse_tick();
    chk("R9", "ch3 keep-first active", rise_w[96 +: 32], tr1 + 2);
    chk("R8", "ch3 rise flag only", {24'd0, stat_w[31:24]}, 32'h05);

    // R5 upper control bits ignored
    wr(0, 8'hFC);
    pulse_tick();
    sig[0] = 1'b1; tr1 = time_w; cyc(4);
    sig[0] = 1'b0; tf1 = time_w; cyc(4);
    sig[0] = 1'b1; tr2 = time_w; cyc(4);
    pulse_tick();
    chk("R5", "ch0 upper bits no effect", rise_w[0 +: 32], tr2 + 2);
    chk("R5", "ch0 fall keep-last", fall_w[0 +: 32], tf1 + 2);
    chk("R5", "ch0 no flags", {24'd0, stat_w[7:0]}, 32'h04);

    // R5 split modes: rise keep-last, fall keep-first on ch2
    wr(2, 8'h02);
    pulse_tick();
    sig[2] = 1'b0; tf1 = time_w; cyc(4);
    sig[2] = 1'b1; cyc(4);
    sig[2] = 1'b0; cyc(4);
    sig[2] = 1'b1; tr2 = time_w; cyc(4);
    pulse_tick();
    chk("R5", "ch2 fall first", fall_w[64 +: 32], tf1 + 2);
    chk("R5", "ch2 rise last", rise_w[64 +: 32], tr2 + 2);
    chk("R5", "ch2 fall flag only", {24'd0, stat_w[23:16]}, 32'h06);

    // random phase, model compared every clock
    for (int i = 0; i < 6000; i++) begin
      for (int c = 0; c < NCH; c++)
        if ($urandom_range(0, 6) == 0) sig[c] = ~sig[c];
      tick = ($urandom_range(0, 14) == 0);
      wr_en = ($urandom_range(0, 40) == 0);
      wr_ch = 2'($urandom_range(0, 3));
      wr_data = 8'($urandom);
      cyc(1);
    end
    tick = 1'b0; wr_en = 1'b0;
    cyc(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule